// File: doc/BRIEF.md
# Supply-Guarded Bus Access Gate

This block is the control front end between a byte-wide asynchronous memory bus and the storage behind it. It takes the three active-low bus strobes (chip select, output enable, write enable) and turns them into an internal read enable, an internal write enable and an enable for the data-bus output drivers. All of this happens in a single synchronous clock domain. The strobes and the two supply flags are brought into that domain through two-flop synchronizers before any decoding.

Access depends on the supply. A low supply-good flag from an external comparator closes the gate at once. So does a battery-domain flag, which means the logic is running from the backup source. When both flags return to their healthy state, the gate stays closed for a recovery interval of 35 ms. A counter times this interval, and its terminal count is derived from the clock frequency. The block also keeps a sticky latch. The latch sets the first time valid supply is seen and arms the backup-source connection, and it stays set across later supply loss.

Top module: `pwr_access_gate`

## Requirements
- R1: With the chip select (`bus_cs_n`) high, `rd_en_o`, `wr_en_o` and `dq_drive_o` are all 0, whatever the other two strobes are.
- R2: With chip select low and write enable (`bus_we_n`) low, `wr_en_o` is 1 and `rd_en_o` and `dq_drive_o` are 0, whatever the output enable is. A write therefore starts at whichever strobe falls last, and a write enable that falls during a read turns the data drivers off.
- R3: With chip select low and write enable high, `rd_en_o` is 1 and `wr_en_o` is 0. `dq_drive_o` is 1 only when output enable (`bus_oe_n`) is also low.
- R4: Bus outputs follow a change on the strobes at the third rising clock edge after the change: two synchronizer stages and one output register. They are unchanged after two edges.
- R5: When `supply_ok_i` falls, `rd_en_o`, `wr_en_o` and `dq_drive_o` are 0 from the third rising edge after the fall. This also aborts a write in progress.
- R6: After `supply_ok_i` rises, with `on_batt_i` low, access stays blocked. With RECOV_CYCLES = CLK_HZ/1e6 × RECOVER_US, the outputs are still blocked after RECOV_CYCLES+2 rising edges and first follow the strobes at edge RECOV_CYCLES+3.
- R7: If the supply flag drops during the recovery count, the count restarts, and the full interval is measured again from the next rise.
- R8: `batt_armed_o` is 0 after reset. It becomes 1 at the third rising edge after `supply_ok_i` is first high, and it stays 1 through any later supply loss until reset.
- R9: While `on_batt_i` is high, `batt_powered_o` is 1 (from the third edge) and access is blocked. After the flag clears, the full recovery interval applies as in R6.
- R10: During and right after reset, all five outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, asynchronous |
| on_batt_i | input | 1 | High when the supply has dropped below backup level, asynchronous |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| rd_en_o | output | 1 | Internal read enable to storage |
| wr_en_o | output | 1 | Internal write enable to storage |
| dq_drive_o | output | 1 | Enable for the data-bus output drivers |
| batt_armed_o | output | 1 | Sticky flag: backup source connected |
| batt_powered_o | output | 1 | Logic is running from the backup source |

## Verification
Every result of this block is due at a fixed edge count after its stimulus. A strobe or supply-flag change reaches the outputs on the third rising edge. The end of recovery appears on edge RECOV_CYCLES+3 after the supply returns. The bench drives inputs on falling edges and samples on falling edges after an exact number of edges. For each latency it checks both the edge just before the result is due (the old value still holds) and the edge on which it is due. The bench shortens the recovery parameter so that these windows can be counted exactly.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_mode_e;
endpackage

// File: rtl/pag_sync.sv
module pag_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pag_recovery.sv
module pag_recovery #(
  parameter int unsigned RECOV_CYCLES = 4375000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_ok_s,
  input  logic on_batt_s,
  output logic gate_ok_o,
  output logic armed_o,
  output logic batt_pwr_o
);
  localparam int unsigned CW = $clog2(RECOV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOV_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          batt_q, batt_d;
  logic          healthy;

  assign healthy = sup_ok_s && !on_batt_s;

  always_comb begin
    cnt_d = cnt_q;
    if (!healthy) begin
      cnt_d = '0;
    end else if (cnt_q != LAST) begin
      cnt_d = cnt_q + 1'b1;
    end
    armed_d = armed_q | sup_ok_s;
    batt_d  = on_batt_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      batt_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      batt_q  <= batt_d;
    end
  end

  assign gate_ok_o  = healthy && (cnt_q == LAST);
  assign armed_o    = armed_q;
  assign batt_pwr_o = batt_q;

  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok_s |=> cnt_q == '0);
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (healthy && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_armed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  assert_batt_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    on_batt_s |=> batt_q);
endmodule

// File: rtl/pag_decode.sv
module pag_decode
  import pag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic oe_n_s,
  input  logic we_n_s,
  input  logic gate_ok_i,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic dq_drive_o
);
  bus_mode_e mode_d;
  logic rd_q, wr_q, drv_q;
  logic rd_d, wr_d, drv_d;

  always_comb begin
    mode_d = BUS_IDLE;
    if (gate_ok_i && !cs_n_s) begin
      mode_d = we_n_s ? BUS_READ : BUS_WRITE;
    end
    rd_d  = (mode_d == BUS_READ);
    wr_d  = (mode_d == BUS_WRITE);
    drv_d = (mode_d == BUS_READ) && !oe_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      drv_q <= drv_d;
    end
  end

  assign rd_en_o    = rd_q;
  assign wr_en_o    = wr_q;
  assign dq_drive_o = drv_q;

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !rd_q && !wr_q && !drv_q);
  assert_write_nodrive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> !drv_q && !rd_q);
  assert_drive_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> rd_q);
  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_ok_i |=> !rd_q && !wr_q && !drv_q);
endmodule

// File: rtl/pwr_access_gate.sv
module pwr_access_gate #(
  parameter int unsigned CLK_HZ     = 125000000,
  parameter int unsigned RECOVER_US = 35000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic on_batt_i,
  input  logic bus_cs_n,
  input  logic bus_oe_n,
  input  logic bus_we_n,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic dq_drive_o,
  output logic batt_armed_o,
  output logic batt_powered_o
);
  localparam int unsigned RECOV_CYCLES = (CLK_HZ / 1000000) * RECOVER_US;

  logic [4:0] raw_in, sync_out;
  logic sup_s, batt_s, cs_s, oe_s, we_s;
  logic gate_ok;

  assign raw_in = {supply_ok_i, on_batt_i, bus_cs_n, bus_oe_n, bus_we_n};

  pag_sync #(.W(5), .RST_VAL(5'b00111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_in),
    .q_o  (sync_out)
  );

  assign {sup_s, batt_s, cs_s, oe_s, we_s} = sync_out;

  pag_recovery #(.RECOV_CYCLES(RECOV_CYCLES)) u_recov (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_ok_s  (sup_s),
    .on_batt_s (batt_s),
    .gate_ok_o (gate_ok),
    .armed_o   (batt_armed_o),
    .batt_pwr_o(batt_powered_o)
  );

  pag_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_s),
    .oe_n_s    (oe_s),
    .we_n_s    (we_s),
    .gate_ok_i (gate_ok),
    .rd_en_o   (rd_en_o),
    .wr_en_o   (wr_en_o),
    .dq_drive_o(dq_drive_o)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> !rd_en_o && !wr_en_o && !dq_drive_o);
endmodule

// File: tb/tb_pwr_access_gate.sv
module tb_pwr_access_gate;
  localparam int unsigned REC = 125;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok_i, on_batt_i, bus_cs_n, bus_oe_n, bus_we_n;
  logic rd_en_o, wr_en_o, dq_drive_o, batt_armed_o, batt_powered_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pwr_access_gate #(.CLK_HZ(125000000), .RECOVER_US(1)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i), .on_batt_i(on_batt_i),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o), .dq_drive_o(dq_drive_o),
    .batt_armed_o(batt_armed_o), .batt_powered_o(batt_powered_o)
  );

  // {cs_n, oe_n, we_n, exp_rd, exp_wr, exp_drive}
  localparam logic [5:0] VEC [8] = '{
    6'b100_000, 6'b111_000, 6'b011_100, 6'b001_101,
    6'b000_010, 6'b010_010, 6'b101_000, 6'b001_101
  };

  task automatic chk(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2:0] bus3();
    return {rd_en_o, wr_en_o, dq_drive_o};
  endfunction

  task automatic run_all();
    // R10 / R8: reset state
    rst_n = 1'b0; supply_ok_i = 1'b0; on_batt_i = 1'b0;
    bus_cs_n = 1'b1; bus_oe_n = 1'b1; bus_we_n = 1'b1;
    cyc(3);
    chk("R10", "bus outputs in reset", bus3(), 3'b000);
    chk("R10", "flags in reset", {1'b0, batt_armed_o, batt_powered_o}, 3'b000);
    rst_n = 1'b1;
    cyc(2);
    chk("R10", "bus outputs after reset", bus3(), 3'b000);
    // R6: recovery window with a read held
    bus_cs_n = 1'b0; bus_oe_n = 1'b0;
    cyc(4);
    supply_ok_i = 1'b1;
    cyc(REC + 2);
    chk("R6", "blocked at last recovery edge", bus3(), 3'b000);
    chk("R8", "armed after first supply", {2'b00, batt_armed_o}, 3'b001);
    cyc(1);
    chk("R6", "open after recovery", bus3(), 3'b101);
    // R1 R2 R3: table walk
    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      string tag;
      v = VEC[i];
      bus_cs_n = v[5]; bus_oe_n = v[4]; bus_we_n = v[3];
      tag = v[5] ? "R1" : (!v[3] ? "R2" : "R3");
      cyc(3);
      chk(tag, $sformatf("vector %0d", i), bus3(), v[2:0]);
    end
    // R4: latency; from deselect to write
    bus_cs_n = 1'b1; bus_we_n = 1'b1; bus_oe_n = 1'b1;
    cyc(4);
    bus_cs_n = 1'b0; bus_we_n = 1'b0;
    cyc(2);
    chk("R4", "unchanged after two edges", bus3(), 3'b000);
    cyc(1);
    chk("R4", "write on third edge", bus3(), 3'b010);
    // R2: we falls during active read turns drivers off
    bus_we_n = 1'b1; bus_oe_n = 1'b0;
    cyc(3);
    chk("R3", "read with drive", bus3(), 3'b101);
    bus_we_n = 1'b0;
    cyc(3);
    chk("R2", "we during read", bus3(), 3'b010);
    // R5: supply fails mid write
    supply_ok_i = 1'b0;
    cyc(2);
    chk("R5", "write still on two edges after fail", bus3(), 3'b010);
    cyc(1);
    chk("R5", "write dropped on third edge", bus3(), 3'b000);
    chk("R8", "armed kept through supply loss", {2'b00, batt_armed_o}, 3'b001);
    // R7: restart of recovery count
    bus_we_n = 1'b1;
    supply_ok_i = 1'b1;
    cyc(50);
    chk("R7", "blocked mid count", bus3(), 3'b000);
    supply_ok_i = 1'b0;
    cyc(5);
    supply_ok_i = 1'b1;
    cyc(REC + 2);
    chk("R7", "still blocked after restarted count", bus3(), 3'b000);
    cyc(1);
    chk("R7", "open after full restarted count", bus3(), 3'b101);
    // R9: battery-domain flag
    on_batt_i = 1'b1;
    cyc(3);
    chk("R9", "battery powered blocks", {bus3()}, 3'b000);
    chk("R9", "battery flag", {2'b00, batt_powered_o}, 3'b001);
    on_batt_i = 1'b0;
    cyc(REC + 2);
    chk("R9", "blocked during recovery after battery", bus3(), 3'b000);
    chk("R9", "battery flag cleared", {2'b00, batt_powered_o}, 3'b000);
    cyc(1);
    chk("R9", "open after recovery from battery", bus3(), 3'b101);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule